// File: doc/BRIEF.md
# Qualified Level Detector with Glitch Rejection

This block watches a single asynchronous digital input, such as the conditioned output of an AC line sensor. It reports a clean "present" flag that rises only after the input has stayed high for a full qualification window. High pulses shorter than the window are rejected. If the input drops while the window is running, qualification is aborted and starts again from the next rising edge.

The raw input passes through a two-flop synchronizer. A third register holds the previous synchronized sample, and a rising edge is found by comparing the current sample with that previous one. That edge is also driven out as a one-cycle strobe.

Both the qualification window and a minimum hold time on the output are given in microseconds. They are converted to cycle counts from a clock-frequency parameter. Once the flag changes, it keeps its new value for at least the hold time. The flag stays at 1 for as long as the synchronized input remains high.

Top module: `level_qualifier`

## Requirements
- R1: The raw input is synchronized by two flops. `rise_strobe` is 1 for exactly one cycle per 0-to-1 transition of the synchronized input. When the raw input is first seen high at clock edge E0, the strobe is high in the cycle that follows edge E1.
- R2: A synchronous reset drives `present` and `rise_strobe` to 0 on the next clock edge, and clears the synchronizer and both counters.
- R3: Let Q = (CLK_HZ/1000000)*QUAL_US. A high pulse that is sampled for Q-1 cycles or fewer never sets `present`.
- R4: A high pulse that is sampled for Q cycles or more sets `present`. With raw first sampled high at edge E0, `present` reads 1 after edge E(Q+1), provided the hold time has expired.
- R5: If the input falls before the window completes, the count is cleared and the block waits for the next rising edge. A later pulse then needs a full Q high cycles, counted from its own first sample.
- R6: While the synchronized input stays high after qualification, `present` stays at 1.
- R7: Let H = (CLK_HZ/1000000)*HOLD_US. After `present` changes, it keeps its value for at least H cycles. After a qualified pulse whose first low sample is at edge E(W), `present` returns to 0 after edge E(max(W+2, Q+1+H)).
- R8: The qualification counter saturates at Q-1 and never wraps while the input stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_in | input | 1 | Asynchronous input level to qualify |
| present | output | 1 | Qualified, hold-limited level flag |
| rise_strobe | output | 1 | One-cycle pulse on each synchronized rising edge |

## Verification
A qualification counter that is off by one shows up at the ports as a pulse of length Q-1 being accepted, or a pulse of length Q being rejected. It also moves the rising edge of `present` by one cycle away from edge E(Q+1), so sweeping the pulse width across the boundary exposes it within a single pulse. A faulty hold counter shifts the falling edge of `present` for the pulses whose fall is set by the hold limit rather than by the input. A faulty synchronizer or edge register moves or repeats the strobe in the first two cycles of a pulse.

// File: rtl/level_qualifier.sv
module level_qualifier #(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned QUAL_US = 2500,
  parameter int unsigned HOLD_US = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic present,
  output logic rise_strobe
);
  localparam int unsigned CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int unsigned QUAL_CYC   = CYC_PER_US * QUAL_US;
  localparam int unsigned HOLD_CYC   = CYC_PER_US * HOLD_US;
  localparam int unsigned QW         = $clog2(QUAL_CYC + 1);
  localparam int unsigned HW         = $clog2(HOLD_CYC + 1);
  localparam logic [QW-1:0] QUAL_LAST = QW'(QUAL_CYC - 1);
  localparam logic [HW-1:0] HOLD_MAX  = HW'(HOLD_CYC);

  // [0] first sync stage, [1] current sample, [2] previous sample
  logic [2:0]    sync_q;
  logic [QW-1:0] qcnt;
  logic [HW-1:0] hcnt;
  logic          cur, prev, want, hold_ok;

  assign cur         = sync_q[1];
  assign prev        = sync_q[2];
  assign rise_strobe = cur & ~prev;
  assign want        = cur && (qcnt == QUAL_LAST);
  assign hold_ok     = (hcnt == HOLD_MAX);

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], raw_in};
  end

  always_ff @(posedge clk) begin
    if (rst || !cur)                       qcnt <= '0;
    else if (rise_strobe)                  qcnt <= QW'(1) & {QW{QUAL_CYC > 1}};
    else if (qcnt != '0 && qcnt < QUAL_LAST) qcnt <= qcnt + QW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      present <= 1'b0;
      hcnt    <= '0;
    end else if (hold_ok && want != present) begin
      present <= want;
      hcnt    <= HW'(1);
    end else if (!hold_ok) begin
      hcnt <= hcnt + HW'(1);
    end
  end

  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (rst)
    rise_strobe |=> !rise_strobe);

  assert_rise_needs_input_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(present) |-> $past(cur));

  assert_fall_on_abort_R5: assert property (@(posedge clk) disable iff (rst)
    (!cur && !prev) |=> (qcnt == '0));

  assert_stays_high_R6: assert property (@(posedge clk) disable iff (rst)
    (present && cur && prev) |=> present);

  assert_hold_time_R7: assert property (@(posedge clk) disable iff (rst)
    (hcnt < HOLD_MAX) |=> $stable(present));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    qcnt <= QUAL_LAST);
endmodule

// File: tb/level_qualifier_bench.sv
`timescale 1ns/1ps
module level_qualifier_bench;
  localparam int unsigned CLK_HZ  = 2_000_000;
  localparam int unsigned QUAL_US = 5;
  localparam int unsigned HOLD_US = 4;
  localparam int Q = (CLK_HZ / 1_000_000) * QUAL_US;
  localparam int H = (CLK_HZ / 1_000_000) * HOLD_US;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw_in = 1'b0;
  logic present, rise_strobe;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  level_qualifier #(.CLK_HZ(CLK_HZ), .QUAL_US(QUAL_US), .HOLD_US(HOLD_US)) u_level_qualifier (
    .clk(clk), .rst(rst), .raw_in(raw_in), .present(present), .rise_strobe(rise_strobe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit level_at(int k, int hi1, int gap, int hi2);
    return (k < hi1) || (k >= hi1 + gap && k < hi1 + gap + hi2);
  endfunction

  task automatic run(input int hi1, input int gap, input int hi2, input int n_cyc,
                     output int rise_n, output int fall_n, output int strobes, output int first_strobe);
    rise_n = -1; fall_n = -1; strobes = 0; first_strobe = -1;
    @(negedge clk);
    raw_in = level_at(0, hi1, gap, hi2);
    for (int n = 0; n < n_cyc; n++) begin
      @(negedge clk);
      if (rise_strobe) begin
        strobes++;
        if (first_strobe < 0) first_strobe = n;
      end
      if (present && rise_n < 0) rise_n = n;
      if (!present && rise_n >= 0 && fall_n < 0) fall_n = n;
      raw_in = level_at(n + 1, hi1, gap, hi2);
    end
    raw_in = 1'b0;
    repeat (Q + H + 6) @(negedge clk);
  endtask

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  initial begin
    #(200000 * 4);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int r, f, s, fs;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(present == 1'b0, "R2 present after reset", present, 0);
    chk(rise_strobe == 1'b0, "R2 strobe after reset", rise_strobe, 0);
    repeat (H + 2) @(negedge clk);

    for (int w = 1; w <= Q + H + 4; w++) begin
      run(w, 0, 0, Q + H + w + 10, r, f, s, fs);
      chk(s == 1 && fs == 1, "R1 strobe count/position", s * 100 + fs, 101);
      if (w < Q) begin
        chk(r < 0, "R3 short pulse rejected", r, -1);
      end else begin
        chk(r == Q + 1, "R4 qualified rise cycle", r, Q + 1);
        chk(f == imax(w + 2, Q + 1 + H), "R6 R7 fall cycle", f, imax(w + 2, Q + 1 + H));
      end
    end

    run(Q - 1, 3, Q + 2, 4 * Q + H + 10, r, f, s, fs);
    chk(s == 2, "R1 two strobes", s, 2);
    chk(r == Q - 1 + 3 + Q + 1, "R5 requalify after abort", r, 2 * Q + 3);
    chk(f == imax(Q - 1 + 3 + Q + 2 + 2, r + H), "R7 fall after requalify", f,
        imax(2 * Q + 6, r + H));

    run(Q - 1, 1, Q - 1, 3 * Q + H + 10, r, f, s, fs);
    chk(r < 0, "R5 two short pulses rejected", r, -1);

    @(negedge clk);
    raw_in = 1'b1;
    repeat (Q + H + 4) @(negedge clk);
    chk(present == 1'b1, "R6 held high", present, 1);
    rst = 1'b1;
    @(negedge clk);
    chk(present == 1'b0, "R2 reset while qualified", present, 0);
    chk(rise_strobe == 1'b0, "R2 strobe during reset", rise_strobe, 0);
    rst = 1'b0;
    raw_in = 1'b0;
    repeat (4) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule